// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking two levels of 4 KB page tables in memory. It reads the directory entry, then the table entry, and stops with a fault as soon as an entry is absent or forbids the access. When an entry's accessed or dirty flag needs to change, it writes the entry back over the same memory port. A request is accepted only while the walker is idle. Each request ends in exactly one single-cycle done or fault pulse. A fault carries a two-bit code that gives the kind of failure and the level at which it happened.

A small directory-entry cache holds the two most recently used directory entries, tagged by the directory index. When the cache is enabled and the lookup hits, the walk skips the directory read and needs only one table read. The cache starts empty because every entry is invalid after reset. It is emptied whenever the enable input is low or the directory base changes value.

Top module: `ptw_top`

## Requirements
- R1: The directory read address is {dir_base, lin[31:22], 2'b00}. The table read address is {directory entry[31:12], lin[21:12], 2'b00}.
- R2: A walk that succeeds raises resp_done for exactly one cycle, with resp_paddr = {table entry[31:12], lin[11:0]}. After reset, busy, resp_done, resp_fault and mem_req are all low.
- R3: If bit 0 (present) of the directory entry is 0, the walk faults with resp_cause 2'b00. No table read is made and no memory write is made.
- R4: If bit 0 of the table entry is 0, the walk faults with resp_cause 2'b01 and no memory write is made.
- R5: An access is a protection fault in two cases: req_user=1 and the entry's bit 2 (user) is 0, or req_write=1 and the entry's bit 1 (writable) is 0. The fault code is 2'b10 at the directory level and 2'b11 at the table level. A protection fault writes nothing to memory.
- R6: If bit 5 (accessed) of a valid directory entry is 0, the entry is written back with bit 5 set before the table read. If bit 5 is already 1, no write is made.
- R7: A good table entry is written back with bit 5 set, and with bit 6 (dirty) also set when the access is a write. The write-back is made only if this changes the entry. A read never sets bit 6.
- R8: While dcache_en is 0, every walk reads the directory entry from memory.
- R9: While dcache_en is 1, a walk whose directory index hits the cache makes exactly one memory read, and that read is the table read.
- R10: The cache keeps the two most recently used directory indices. A miss replaces the least recently used entry.
- R11: When dir_base changes value, the next walk misses the cache. Taking dcache_en low also empties the cache.
- R12: resp_done and resp_fault are never high together. mem_req, mem_addr and mem_we hold steady until mem_ack arrives.
- R13: busy is high from the cycle after a request is accepted until the response. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request, taken only while idle |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user level |
| dir_base | input | 20 | Page frame number of the directory table |
| dcache_en | input | 1 | Enables the directory-entry cache |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete, one cycle |
| resp_done | output | 1 | Translation done pulse |
| resp_fault | output | 1 | Page fault pulse |
| resp_cause | output | 2 | Fault code: bit 1 = protection, bit 0 = table level |
| resp_paddr | output | 32 | Physical address |

## Verification
The assertions assume a memory that answers each request with a single-cycle mem_ack and never raises mem_ack without a pending request. They also assume that dir_base stays stable while a walk is in progress. The bench memory model acknowledges one cycle after it sees a new request. The bench changes dir_base and dcache_en only while the walker is idle, and it waits a few cycles before issuing the next request. Requests are raised for one cycle at a time, including the deliberate request made while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W  = 32;
    localparam int PFN_W   = 20;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;

    localparam int BIT_PRES  = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_USER  = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB
    } walk_state_e;

    typedef enum logic [1:0] {
        FC_DIR_ABSENT = 2'b00,
        FC_TBL_ABSENT = 2'b01,
        FC_DIR_PROT   = 2'b10,
        FC_TBL_PROT   = 2'b11
    } fault_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lin;
        logic              wr;
        logic              usr;
    } walk_req_t;

    function automatic logic [ADDR_W-1:0] dir_entry_addr(
        input logic [PFN_W-1:0] base, input logic [ADDR_W-1:0] lin);
        return {base, lin[ADDR_W-1:ADDR_W-IDX_W], 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] tbl_entry_addr(
        input logic [ADDR_W-1:0] dent, input logic [ADDR_W-1:0] lin);
        return {dent[ADDR_W-1:OFF_W], lin[OFF_W+IDX_W-1:OFF_W], 2'b00};
    endfunction
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic [2:0] attr,
    input  logic       wr,
    input  logic       usr,
    output logic       absent,
    output logic       denied
);
    import ptw_pkg::*;

    assign absent = !attr[BIT_PRES];
    assign denied = (usr && !attr[BIT_USER]) || (wr && !attr[BIT_WR]);
endmodule

// File: rtl/ptw_dcache.sv
module ptw_dcache #(
    parameter int WAYS   = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              touch_en,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]   vld_q;
    logic [WAYS-1:0]   hit_vec;
    logic [TAG_W-1:0]  tag_q [WAYS];
    logic [DATA_W-1:0] dat_q [WAYS];
    logic [AGE_W-1:0]  age_q [WAYS];
    logic [AGE_W-1:0]  hit_idx;
    logic [AGE_W-1:0]  vic_idx;
    logic [AGE_W-1:0]  upd_idx;
    logic              upd_en;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_way
            assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
        end
    endgenerate

    always_comb begin
        hit      = |hit_vec;
        hit_data = '0;
        hit_idx  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) begin
                hit_data = dat_q[i];
                hit_idx  = AGE_W'(i);
            end
        end
    end

    // Oldest way is the victim unless an invalid way exists (lowest first).
    always_comb begin
        vic_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (age_q[i] == AGE_W'(WAYS - 1)) vic_idx = AGE_W'(i);
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld_q[i]) vic_idx = AGE_W'(i);
        end
    end

    assign upd_en  = fill_en || (touch_en && hit);
    assign upd_idx = fill_en ? vic_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < WAYS; i++) begin
                age_q[i] <= AGE_W'(i);
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else if (upd_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (AGE_W'(i) == upd_idx) age_q[i] <= '0;
                else if (age_q[i] < age_q[upd_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
            if (fill_en) begin
                vld_q[upd_idx] <= 1'b1;
                tag_q[upd_idx] <= fill_tag;
                dat_q[upd_idx] <= fill_data;
            end
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
    parameter int DC_WAYS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_lin,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [19:0] dir_base,
    input  logic        dcache_en,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        resp_done,
    output logic        resp_fault,
    output logic [1:0]  resp_cause,
    output logic [31:0] resp_paddr
);
    import ptw_pkg::*;

    localparam logic [ADDR_W-1:0] ACC_MASK   = ADDR_W'(1) << BIT_ACC;
    localparam logic [ADDR_W-1:0] DIRTY_MASK = ADDR_W'(1) << BIT_DIRTY;

    walk_state_e       st_q;
    walk_req_t         rq_q;
    logic [PFN_W-1:0]  base_q;
    logic [ADDR_W-1:0] pde_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] pte_next;
    logic [ADDR_W-1:0] dir_src;

    logic dc_flush, dc_hit, dc_use, dc_touch, dc_fill;
    logic [ADDR_W-1:0] dc_data, dc_fill_data;
    logic dir_absent, dir_denied, tbl_absent, tbl_denied;
    logic chk_wr, chk_usr;

    // Cache contents are dropped whenever the cache is off or the base moves.
    assign dc_flush = !dcache_en || (dir_base != base_q);
    assign dc_use   = dc_hit && !dc_flush;
    assign dc_touch = (st_q == ST_IDLE) && req_valid;

    assign dc_fill  = dcache_en && !dc_flush && mem_ack &&
                      (((st_q == ST_DIR_RD) && !dir_absent && !dir_denied &&
                        mem_rdata[BIT_ACC]) || (st_q == ST_DIR_WB));
    assign dc_fill_data = (st_q == ST_DIR_RD) ? mem_rdata : pde_q;

    ptw_dcache #(
        .WAYS   (DC_WAYS),
        .TAG_W  (IDX_W),
        .DATA_W (ADDR_W)
    ) i_dcache (
        .clk       (clk),
        .rst       (rst),
        .flush     (dc_flush),
        .lk_tag    (req_lin[ADDR_W-1:ADDR_W-IDX_W]),
        .touch_en  (dc_touch),
        .fill_en   (dc_fill),
        .fill_tag  (rq_q.lin[ADDR_W-1:ADDR_W-IDX_W]),
        .fill_data (dc_fill_data),
        .hit       (dc_hit),
        .hit_data  (dc_data)
    );

    // Directory check sees the cached entry at accept time, memory data later.
    assign dir_src = (st_q == ST_IDLE) ? dc_data : mem_rdata;
    assign chk_wr  = (st_q == ST_IDLE) ? req_write : rq_q.wr;
    assign chk_usr = (st_q == ST_IDLE) ? req_user  : rq_q.usr;

    ptw_perm i_dir_perm (
        .attr   (dir_src[2:0]),
        .wr     (chk_wr),
        .usr    (chk_usr),
        .absent (dir_absent),
        .denied (dir_denied)
    );

    ptw_perm i_tbl_perm (
        .attr   (mem_rdata[2:0]),
        .wr     (rq_q.wr),
        .usr    (rq_q.usr),
        .absent (tbl_absent),
        .denied (tbl_denied)
    );

    assign pte_next = mem_rdata | ACC_MASK | (rq_q.wr ? DIRTY_MASK : '0);

    assign busy      = (st_q != ST_IDLE);
    assign mem_req   = (st_q != ST_IDLE);
    assign mem_we    = (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
    assign mem_addr  = ((st_q == ST_DIR_RD) || (st_q == ST_DIR_WB))
                       ? dir_entry_addr(dir_base, rq_q.lin)
                       : tbl_entry_addr(pde_q, rq_q.lin);
    assign mem_wdata = (st_q == ST_DIR_WB) ? pde_q : pte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            rq_q       <= '0;
            base_q     <= '0;
            pde_q      <= '0;
            pte_q      <= '0;
            resp_done  <= 1'b0;
            resp_fault <= 1'b0;
            resp_cause <= '0;
            resp_paddr <= '0;
        end else begin
            base_q     <= dir_base;
            resp_done  <= 1'b0;
            resp_fault <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_q <= '{lin: req_lin, wr: req_write, usr: req_user};
                        if (dc_use) begin
                            pde_q <= dc_data;
                            if (dir_denied) begin
                                resp_fault <= 1'b1;
                                resp_cause <= FC_DIR_PROT;
                            end else begin
                                st_q <= ST_TBL_RD;
                            end
                        end else begin
                            st_q <= ST_DIR_RD;
                        end
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        if (dir_absent || dir_denied) begin
                            st_q       <= ST_IDLE;
                            resp_fault <= 1'b1;
                            resp_cause <= dir_absent ? FC_DIR_ABSENT : FC_DIR_PROT;
                        end else begin
                            pde_q <= mem_rdata | ACC_MASK;
                            st_q  <= mem_rdata[BIT_ACC] ? ST_TBL_RD : ST_DIR_WB;
                        end
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ack) st_q <= ST_TBL_RD;
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        if (tbl_absent || tbl_denied) begin
                            st_q       <= ST_IDLE;
                            resp_fault <= 1'b1;
                            resp_cause <= tbl_absent ? FC_TBL_ABSENT : FC_TBL_PROT;
                        end else begin
                            pte_q <= pte_next;
                            if (pte_next != mem_rdata) begin
                                st_q <= ST_TBL_WB;
                            end else begin
                                st_q       <= ST_IDLE;
                                resp_done  <= 1'b1;
                                resp_paddr <= {mem_rdata[ADDR_W-1:OFF_W], rq_q.lin[OFF_W-1:0]};
                            end
                        end
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ack) begin
                        st_q       <= ST_IDLE;
                        resp_done  <= 1'b1;
                        resp_paddr <= {pte_q[ADDR_W-1:OFF_W], rq_q.lin[OFF_W-1:0]};
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_lin,
    input logic        req_write,
    input logic        req_user,
    input logic [19:0] dir_base,
    input logic        dcache_en,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata,
    input logic        mem_ack,
    input logic        resp_done,
    input logic        resp_fault,
    input logic [1:0]  resp_cause,
    input logic [31:0] resp_paddr
);
    assert_done_fault_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(resp_done && resp_fault));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);

    assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[5]);

    assert_nocache_dir_read_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !dcache_en) |=>
        (mem_req && !mem_we && mem_addr == {$past(dir_base), $past(req_lin[31:22]), 2'b00}));

    assert_busy_after_accept_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy || resp_fault));

    assert_idle_at_resp_R13: assert property (@(posedge clk) disable iff (rst)
        (resp_done || resp_fault) |-> !busy);
endmodule

bind ptw_top ptw_checker i_chk (.*);

// File: tb/test_ptw_top.sv
module test_ptw_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] dir_base = 20'h00010;
    logic        dcache_en = 1'b0;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        resp_done, resp_fault;
    logic [1:0]  resp_cause;
    logic [31:0] resp_paddr;

    int n_checks = 0;
    int n_errs   = 0;

    logic [31:0] mem_arr [logic [29:0]];
    int          tot_rd = 0;
    int          tot_wr = 0;
    logic [31:0] rd_log [256];

    logic        g_done, g_fault;
    logic [1:0]  g_cause;
    logic [31:0] g_paddr;
    int          d_rd, d_wr;
    logic [31:0] first_rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptw_top i_ptw_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .dcache_en(dcache_en), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .resp_done(resp_done), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_paddr(resp_paddr)
    );

    // Memory model: acknowledges one cycle after a new request.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_arr[mem_addr[31:2]] = mem_wdata;
                tot_wr++;
            end else begin
                mem_rdata <= mem_arr.exists(mem_addr[31:2]) ? mem_arr[mem_addr[31:2]] : 32'h0;
                rd_log[tot_rd[7:0]] = mem_addr;
                tot_rd++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem_arr.exists(a[31:2]) ? mem_arr[a[31:2]] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] lin, input logic wr, input logic usr);
        int rd0, wr0;
        bit got;
        @(negedge clk);
        rd0 = tot_rd; wr0 = tot_wr;
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0;
        for (int i = 0; i < 60; i++) begin
            if (resp_done || resp_fault) begin got = 1; break; end
            @(negedge clk);
        end
        g_done = resp_done; g_fault = resp_fault;
        g_cause = resp_cause; g_paddr = resp_paddr;
        d_rd = tot_rd - rd0; d_wr = tot_wr - wr0;
        first_rd = rd_log[rd0[7:0]];
        if (!got) begin
            n_checks++; n_errs++;
            $display("FAIL R2 actual no response expected a response for %h", lin);
        end
        if (g_done && g_fault) begin
            n_checks++; n_errs++;
            $display("FAIL R12 actual done and fault expected one of them");
        end
    endtask

    task automatic t_reset;
        chk("R2 busy at reset", 32'(busy), 32'd0);
        chk("R2 done at reset", 32'(resp_done), 32'd0);
        chk("R2 fault at reset", 32'(resp_fault), 32'd0);
        chk("R2 mem_req at reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_basic;
        walk(32'h0040_1234, 1'b0, 1'b1);
        chk("R2 done", 32'(g_done), 32'd1);
        chk("R2 paddr", g_paddr, 32'h0003_0234);
        chk("R1 dir read addr", first_rd, 32'h0001_0004);
        chk("R1 tbl read addr", rd_log[(tot_rd - 1) % 256], 32'h0002_0004);
        chk("R6 reads", 32'(d_rd), 32'd2);
        chk("R6 one write", 32'(d_wr), 32'd1);
        chk("R6 dir accessed set", peek(32'h0001_0004), 32'h0002_0027);
        walk(32'h0040_1234, 1'b0, 1'b1);
        chk("R6 no write when set", 32'(d_wr), 32'd0);
        chk("R8 dir read without cache", 32'(d_rd), 32'd2);
    endtask

    task automatic t_dirty;
        walk(32'h0040_1234, 1'b1, 1'b1);
        chk("R7 write done", 32'(g_done), 32'd1);
        chk("R7 dirty write", 32'(d_wr), 32'd1);
        chk("R7 dirty value", peek(32'h0002_0004), 32'h0003_0067);
        walk(32'h0040_1ffc, 1'b1, 1'b1);
        chk("R7 no second write", 32'(d_wr), 32'd0);
        chk("R2 paddr after dirty", g_paddr, 32'h0003_0ffc);
    endtask

    task automatic t_access_read;
        walk(32'h0040_2abc, 1'b0, 1'b1);
        chk("R7 read paddr", g_paddr, 32'h0003_1abc);
        chk("R7 read write-back", 32'(d_wr), 32'd1);
        chk("R7 read sets only accessed", peek(32'h0002_0008), 32'h0003_1025);
    endtask

    task automatic t_faults;
        walk(32'h0040_2000, 1'b1, 1'b1);
        chk("R5 tbl prot fault", 32'(g_fault), 32'd1);
        chk("R5 tbl prot cause", 32'(g_cause), 32'd3);
        chk("R5 tbl prot no write", 32'(d_wr), 32'd0);
        walk(32'h0080_0000, 1'b0, 1'b0);
        chk("R3 dir absent fault", 32'(g_fault), 32'd1);
        chk("R3 dir absent cause", 32'(g_cause), 32'd0);
        chk("R3 single read", 32'(d_rd), 32'd1);
        chk("R3 no write", 32'(d_wr), 32'd0);
        walk(32'h0040_3000, 1'b0, 1'b0);
        chk("R4 tbl absent fault", 32'(g_fault), 32'd1);
        chk("R4 tbl absent cause", 32'(g_cause), 32'd1);
        chk("R4 two reads", 32'(d_rd), 32'd2);
        chk("R4 no write", 32'(d_wr), 32'd0);
        walk(32'h00C0_0000, 1'b0, 1'b1);
        chk("R5 dir prot cause", 32'(g_cause), 32'd2);
        chk("R5 dir prot one read", 32'(d_rd), 32'd1);
        chk("R5 dir prot no write", 32'(d_wr), 32'd0);
    endtask

    task automatic t_busy;
        int rd0;
        bit extra;
        @(negedge clk);
        rd0 = tot_rd;
        req_valid = 1'b1; req_lin = 32'h0040_1234; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 busy after accept", 32'(busy), 32'd1);
        req_valid = 1'b1; req_lin = 32'h0100_0000;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (resp_done || resp_fault) break;
            @(negedge clk);
        end
        chk("R13 first request answered", resp_paddr, 32'h0003_0234);
        chk("R13 busy low at response", 32'(busy), 32'd0);
        extra = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (resp_done || resp_fault || busy) extra = 1;
        end
        chk("R13 busy request ignored", 32'(extra), 32'd0);
        chk("R13 reads of one walk", 32'(tot_rd - rd0), 32'd2);
    endtask

    task automatic t_cache;
        @(negedge clk); dcache_en = 1'b1;
        repeat (2) @(negedge clk);
        walk(32'h0040_1234, 1'b0, 1'b1);
        chk("R9 miss reads", 32'(d_rd), 32'd2);
        walk(32'h0040_1234, 1'b0, 1'b1);
        chk("R9 hit reads", 32'(d_rd), 32'd1);
        chk("R9 hit reads table", first_rd, 32'h0002_0004);
        chk("R9 hit paddr", g_paddr, 32'h0003_0234);
    endtask

    task automatic t_lru;
        walk(32'h0100_0000, 1'b0, 1'b0);
        chk("R10 fill second", 32'(d_rd), 32'd2);
        chk("R10 paddr idx4", g_paddr, 32'h0003_2000);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R10 touch idx1", 32'(d_rd), 32'd1);
        walk(32'h0140_0000, 1'b0, 1'b0);
        chk("R10 fill idx5", 32'(d_rd), 32'd2);
        chk("R10 paddr idx5", g_paddr, 32'h0003_3000);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R10 recent kept", 32'(d_rd), 32'd1);
        walk(32'h0100_0000, 1'b0, 1'b0);
        chk("R10 oldest evicted", 32'(d_rd), 32'd2);
    endtask

    task automatic t_base;
        @(negedge clk); dir_base = 20'h00011;
        repeat (2) @(negedge clk);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R11 miss after base change", 32'(d_rd), 32'd2);
        chk("R11 new base addr", first_rd, 32'h0001_1004);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R11 hit after refill", 32'(d_rd), 32'd1);
        @(negedge clk); dcache_en = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); dcache_en = 1'b1;
        repeat (2) @(negedge clk);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R11 disable empties cache", 32'(d_rd), 32'd2);
        @(negedge clk); dcache_en = 1'b0;
        repeat (2) @(negedge clk);
        walk(32'h0040_1234, 1'b0, 1'b0);
        chk("R8 disabled reads directory", 32'(d_rd), 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        mem_arr[30'h0001_0004 >> 2] = 32'h0002_0007;
        mem_arr[30'h0001_0008 >> 2] = 32'h0000_0000;
        mem_arr[30'h0001_000C >> 2] = 32'h0002_1023;
        mem_arr[30'h0001_0010 >> 2] = 32'h0002_2027;
        mem_arr[30'h0001_0014 >> 2] = 32'h0002_3027;
        mem_arr[30'h0001_1004 >> 2] = 32'h0002_0027;
        mem_arr[30'h0002_0004 >> 2] = 32'h0003_0027;
        mem_arr[30'h0002_0008 >> 2] = 32'h0003_1005;
        mem_arr[30'h0002_000C >> 2] = 32'h0000_0000;
        mem_arr[30'h0002_2000 >> 2] = 32'h0003_2027;
        mem_arr[30'h0002_3000 >> 2] = 32'h0003_3027;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dirty();
        t_access_read();
        t_faults();
        t_busy();
        t_cache();
        t_lru();
        t_base();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule